// File: doc/BRIEF.md
# Random TLB Replacement Index Generator

This block supplies a pseudo-random slot number for refilling a translation lookaside buffer. A caller asks for an index by presenting the current entry count and the number of locked (wired) low entries. The block advances a 32-bit right-shifting Galois LFSR and divides its state by the size of the unlocked region. It adds the wired count to the remainder. The result therefore always lands in the replaceable part of the buffer.

Two rules keep the sequence useful. First, an index equal to the one handed out last time is discarded; the LFSR is stepped again and a fresh remainder is taken. Second, when the unlocked region holds one entry or fewer, the wired count is returned at once. No retry is made, because a retry could never terminate in that case.

The request side is a valid/ready pair: `req_ready` is high only while the block is idle. The reduction takes several dozen cycles, and the entry and wired counts must stay steady from acceptance until the result is taken. The result side is a valid/ready pair with full back-pressure. Once `idx_valid` rises, `idx` holds its value until `idx_ready` is seen high at a clock edge. In the cycle after that, `idx_valid` is low and a new request may be accepted.

Top module: `tlb_rand_idx`

## Requirements
- R1: After reset `req_ready` is 1, `idx_valid` is 0, the LFSR state is 1 and the remembered last index is 0.
- R2: Each LFSR step shifts the 32-bit state right by one; when the bit shifted out was 1 the shifted value is XORed with 0xD0000001, otherwise it is left as is.
- R3: For a span (entry count minus wired count) of 2 or more, the block steps the LFSR once and forms the candidate (LFSR mod span) + wired, which lies in [wired, entry count - 1].
- R4: For a span of 2 or more, a returned index never equals the index returned by the previous completed request.
- R5: A candidate equal to the last returned index is rejected; the LFSR steps again and a new candidate is formed, repeating until they differ.
- R6: When the entry count is at most the wired count plus one, the wired count is returned, the LFSR is not stepped, and the remembered index becomes the wired count.
- R7: A request is taken only in a cycle where `req_valid` and `req_ready` are both high; `req_ready` is low from acceptance until the result has been taken, and `req_ready` and `idx_valid` are never high together.
- R8: While `idx_valid` is high and `idx_ready` is low, `idx_valid` stays high and `idx` does not change; after a cycle with both high, `idx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Caller requests a new index |
| req_ready | output | 1 | Block is idle and will take a request |
| entry_cnt | input | CNT_W | Number of TLB entries; held while busy |
| wired_cnt | input | CNT_W | Number of locked low entries; held while busy |
| idx_valid | output | 1 | `idx` holds a final result |
| idx_ready | input | 1 | Caller takes the result |
| idx | output | CNT_W | Replacement index |

## Verification
The checker watches the handshake rules on every cycle: a held result stays stable, the two ready/valid sides never overlap, and `idx_valid` drops after a handshake. On each presented result it also checks the range bound, the repeat exclusion against the last index taken, and the degenerate-span answer. Only the bench's scenarios show that the exact LFSR sequence, the retry count and the absence of a step in the degenerate case match a reference model. They also show that reset restarts the sequence from seed 1, and that a request pulsed during back-pressure is ignored.

// File: rtl/tlb_rand_pkg.sv
package tlb_rand_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_REDUCE = 2'd2,
    ST_HOLD   = 2'd3
  } ctl_state_e;
endpackage

// File: rtl/tlb_rand_lfsr.sv
// Right-shifting Galois LFSR; one step per cycle with step high.
module tlb_rand_lfsr #(
  parameter int          W    = 32,
  parameter logic [W-1:0] TAPS = 32'hD000_0001,
  parameter logic [W-1:0] SEED = 32'h0000_0001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] state
);
  logic [W-1:0] nxt;
  logic         fb;

  assign fb = state[0];

  // Each bit takes its upper neighbour, XORed with the feedback where a tap sits.
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (b == W - 1) begin : g_top
      assign nxt[b] = fb & TAPS[b];
    end else begin : g_mid
      assign nxt[b] = state[b+1] ^ (fb & TAPS[b]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= SEED;
    else if (step) state <= nxt;
  end
endmodule

// File: rtl/tlb_rand_rem.sv
// Restoring remainder unit: one dividend bit per cycle, MSB first.
module tlb_rand_rem #(
  parameter int DW = 32,
  parameter int RW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [RW-1:0] divisor,
  output logic          done,
  output logic [RW-1:0] rem
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] shreg;
  logic [CW-1:0] left;
  logic [RW:0]   trial;
  logic          fits;

  assign trial = {rem, shreg[DW-1]};
  assign fits  = trial >= {1'b0, divisor};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      left  <= '0;
      rem   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        shreg <= dividend;
        rem   <= '0;
        left  <= CW'(DW);
      end else if (left != '0) begin
        rem   <= fits ? RW'(trial - {1'b0, divisor}) : trial[RW-1:0];
        shreg <= {shreg[DW-2:0], 1'b0};
        left  <= left - 1'b1;
        if (left == CW'(1)) done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlb_rand_idx.sv
module tlb_rand_idx
  import tlb_rand_pkg::*;
#(
  parameter int          CNT_W  = 7,
  parameter int          LFSR_W = 32,
  parameter logic [31:0] TAPS   = 32'hD000_0001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CNT_W-1:0] entry_cnt,
  input  logic [CNT_W-1:0] wired_cnt,
  output logic             idx_valid,
  input  logic             idx_ready,
  output logic [CNT_W-1:0] idx
);
  ctl_state_e        state_q;
  logic [CNT_W-1:0]  wired_q, span_q, prev_q;
  logic [CNT_W-1:0]  span_in, cand;
  logic [LFSR_W-1:0] lfsr_val;
  logic              lfsr_step, div_start, div_done;
  logic [CNT_W-1:0]  div_rem;
  logic              accept;

  assign req_ready = (state_q == ST_IDLE);
  assign idx_valid = (state_q == ST_HOLD);
  assign accept    = req_valid && req_ready;
  assign span_in   = (entry_cnt > wired_cnt) ? CNT_W'(entry_cnt - wired_cnt) : '0;
  assign cand      = CNT_W'(div_rem + wired_q);

  // Step on a normal accept, and again on every rejected candidate.
  assign lfsr_step = (accept && span_in > CNT_W'(1)) ||
                     (state_q == ST_REDUCE && div_done && cand == prev_q);
  assign div_start = (state_q == ST_LAUNCH);

  tlb_rand_lfsr #(.W(LFSR_W), .TAPS(LFSR_W'(TAPS)), .SEED(LFSR_W'(1))) lfsr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (lfsr_step),
    .state (lfsr_val)
  );

  tlb_rand_rem #(.DW(LFSR_W), .RW(CNT_W)) rem_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (lfsr_val),
    .divisor  (span_q),
    .done     (div_done),
    .rem      (div_rem)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wired_q <= '0;
      span_q  <= '0;
      prev_q  <= '0;
      idx     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          wired_q <= wired_cnt;
          span_q  <= span_in;
          if (span_in <= CNT_W'(1)) begin
            idx     <= wired_cnt;
            prev_q  <= wired_cnt;
            state_q <= ST_HOLD;
          end else begin
            state_q <= ST_LAUNCH;
          end
        end
        ST_LAUNCH: state_q <= ST_REDUCE;
        ST_REDUCE: if (div_done) begin
          if (cand == prev_q) begin
            state_q <= ST_LAUNCH;
          end else begin
            idx     <= cand;
            prev_q  <= cand;
            state_q <= ST_HOLD;
          end
        end
        ST_HOLD: if (idx_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tlb_rand_idx_chk.sv
module tlb_rand_idx_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [CNT_W-1:0] entry_cnt,
  input logic [CNT_W-1:0] wired_cnt,
  input logic             idx_valid,
  input logic             idx_ready,
  input logic [CNT_W-1:0] idx
);
  logic [CNT_W-1:0] last_taken;
  logic [CNT_W-1:0] span;

  assign span = (entry_cnt > wired_cnt) ? CNT_W'(entry_cnt - wired_cnt) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_taken <= '0;
    else if (idx_valid && idx_ready) last_taken <= idx;
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && idx_valid)); // R7

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid && !idx_ready |=> idx_valid && $stable(idx)); // R8

  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid && idx_ready |=> !idx_valid); // R8

  AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid && span > CNT_W'(1) |-> idx >= wired_cnt && idx < entry_cnt); // R3

  AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid && span > CNT_W'(1) |-> idx != last_taken); // R4

  AST_DEGENERATE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid && span <= CNT_W'(1) |-> idx == wired_cnt); // R6
endmodule

bind tlb_rand_idx tlb_rand_idx_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .entry_cnt (entry_cnt),
  .wired_cnt (wired_cnt),
  .idx_valid (idx_valid),
  .idx_ready (idx_ready),
  .idx       (idx)
);

// File: tb/tlb_rand_idx_tb_top.sv
module tlb_rand_idx_tb_top;
  localparam int CNT_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic idx_ready = 1'b0;
  logic [CNT_W-1:0] entry_cnt = '0;
  logic [CNT_W-1:0] wired_cnt = '0;
  logic req_ready, idx_valid;
  logic [CNT_W-1:0] idx;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [31:0] m_lfsr;
  int          m_prev;

  always #2 clk = ~clk;

  tlb_rand_idx #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .entry_cnt(entry_cnt), .wired_cnt(wired_cnt), .idx_valid(idx_valid),
    .idx_ready(idx_ready), .idx(idx)
  );

  // {entry, wired, request count}
  localparam logic [19:0] VEC [10] = '{
    {7'd64, 7'd0,  6'd6}, {7'd64, 7'd8,  6'd4}, {7'd48, 7'd16, 6'd4},
    {7'd10, 7'd3,  6'd4}, {7'd9,  7'd7,  6'd5}, {7'd33, 7'd1,  6'd3},
    {7'd64, 7'd63, 6'd2}, {7'd5,  7'd9,  6'd2}, {7'd64, 7'd62, 6'd4},
    {7'd16, 7'd0,  6'd4}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] step_model(input logic [31:0] s); // R2
    return (s >> 1) ^ (s[0] ? 32'hD000_0001 : 32'h0);
  endfunction

  function automatic int model_next(input int e, input int w);
    int span, c;
    span = (e > w) ? e - w : 0;
    if (span <= 1) begin // R6
      m_prev = w;
      return w;
    end
    do begin // R5 retry
      m_lfsr = step_model(m_lfsr);
      c = int'(m_lfsr % 32'(span)) + w; // R3
    end while (c == m_prev);
    m_prev = c;
    return c;
  endfunction

  task automatic wait_valid();
    int t = 0;
    while (!idx_valid && t < 2000) begin
      @(negedge clk);
      t++;
    end
  endtask

  // Request, wait for the result, compare, then take it.
  task automatic one_req(input int e, input int w, input string tag);
    int exp;
    @(negedge clk);
    entry_cnt = CNT_W'(e);
    wired_cnt = CNT_W'(w);
    idx_ready = 1'b1;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R7 busy after accept"}, int'(req_ready), 0);
    wait_valid();
    exp = model_next(e, w);
    chk({tag, " R3/R4/R5 index"}, int'(idx), exp);
    @(negedge clk);
    chk({tag, " R8 valid drops after take"}, int'(idx_valid), 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0;
    idx_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_lfsr = 32'd1;
    m_prev = 0;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int held;
    do_reset();
    chk("R1 req_ready after reset", int'(req_ready), 1);
    chk("R1 idx_valid after reset", int'(idx_valid), 0);

    foreach (VEC[v]) begin
      for (int k = 0; k < int'(VEC[v][5:0]); k++)
        one_req(int'(VEC[v][19:13]), int'(VEC[v][12:6]), $sformatf("vec%0d", v));
    end

    // R8 back-pressure, with a stray request that must be ignored (R7)
    @(negedge clk);
    entry_cnt = 7'd40; wired_cnt = 7'd4; idx_ready = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_valid();
    held = int'(idx);
    chk("R3 held result", held, model_next(40, 4));
    req_valid = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R8 held valid", int'(idx_valid), 1);
      chk("R8 held idx", int'(idx), held);
      chk("R7 ready low while held", int'(req_ready), 0);
    end
    req_valid = 1'b0;
    idx_ready = 1'b1;
    @(negedge clk);
    chk("R8 valid drops", int'(idx_valid), 0);
    chk("R7 ready after take", int'(req_ready), 1);
    one_req(40, 4, "after-stray R7");

    // R6: degenerate requests do not step the LFSR; following result proves it
    one_req(20, 19, "R6 span1");
    one_req(20, 20, "R6 span0");
    one_req(20, 0, "R6 no-step follow");

    // R1: reset restarts seed and last index
    do_reset();
    chk("R1 ready after 2nd reset", int'(req_ready), 1);
    one_req(64, 0, "R1 reseed a");
    one_req(2, 0, "R1 reseed span2");
    one_req(2, 0, "R4 alternate");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule